// File: doc/BRIEF.md
# Dual-LUT Logic Slice with Distributed RAM

This block is one logic slice of a programmable fabric. It holds two 4-input lookup tables, a flip-flop behind each table, a pair of wide-function multiplexers and a two-bit ripple carry chain.

The lookup tables can be used in three ways:

- As two separate 4-input functions.
- Merged by a select input into a single 5-input function.
- Merged with the 5-input result of a neighbouring slice into a 6-input function.

With the memory mode input raised, the two tables become a 16-word by 2-bit memory. Writes are synchronous and reads are combinational, and both use one shared address.

The tables are loaded through memory mode, so the slice needs no separate configuration port. Contents written there stay in place when the slice returns to logic mode. Routing around the slice is not part of this block.

Top module: `logic_slice2`

## Requirements
- R1: While rst_n is low, both table contents are cleared to zero and q_a and q_b are 0. After reset, y_a, y_b, mux5, mux6, q_a and q_b all read 0 until a table is written.
- R2: In logic mode (mem_mode=0) with share_in=0, y_a is bit addr_a of table A and y_b is bit addr_b of table B. The bit index equals the unsigned address value.
- R3: q_a and q_b take the values y_a and y_b had just before each rising clock edge.
- R4: mux5 equals y_b when sel5=1 and y_a when sel5=0. With share_in=1, table B is indexed by addr_a. A 32-bit truth table T, with its low half in table A and its high half in table B, then gives mux5 = T[{sel5, addr_a}].
- R5: mux6 equals nb_mux5 when sel6=1 and mux5 when sel6=0.
- R6: {cout, sum} equals add_a + add_b + cin. The carry out of bit 0 feeds bit 1, and only the carry out of bit 1 leaves the slice.
- R7: When mem_mode=1 and we=1 at a rising edge, wd[0] is stored in table A and wd[1] in table B, both at word addr_a. Before that edge, the reads still show the old word.
- R8: When mem_mode=1, table B is read at addr_a, and addr_b has no effect.
- R9: With mem_mode=0, we and wd leave both tables unchanged. Contents written in memory mode persist after returning to logic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_mode | input | 1 | 1 selects memory mode, 0 selects logic mode |
| share_in | input | 1 | In logic mode, indexes table B with addr_a |
| we | input | 1 | Write enable (memory mode only) |
| wd | input | 2 | Write data; bit 0 to table A, bit 1 to table B |
| addr_a | input | 4 | Table A inputs; shared address in memory mode |
| addr_b | input | 4 | Table B inputs in independent logic mode |
| sel5 | input | 1 | Fifth input, selects between table outputs |
| sel6 | input | 1 | Sixth input, selects the neighbour's wide result |
| nb_mux5 | input | 1 | 5-input result from the neighbouring slice |
| add_a | input | 2 | Adder operand a |
| add_b | input | 2 | Adder operand b |
| cin | input | 1 | Carry into bit 0 |
| y_a | output | 1 | Unregistered table A output |
| y_b | output | 1 | Unregistered table B output |
| q_a | output | 1 | Registered table A output |
| q_b | output | 1 | Registered table B output |
| mux5 | output | 1 | 5-input function result |
| mux6 | output | 1 | 6-input function result |
| sum | output | 2 | Sum bits of the carry chain |
| cout | output | 1 | Carry out of bit 1 |

## Verification
The table reads, mux5, mux6 and the carry chain are combinational, so their results are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. q_a and q_b are due one rising edge after their inputs settle, and they are sampled one nanosecond after that edge. A memory write lands on the write edge itself: the bench samples the old word just before that edge and the new word just after it.

// File: rtl/logic_slice2.sv
module logic_slice2 #(
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mem_mode,
  input  logic         share_in,
  input  logic         we,
  input  logic [1:0]   wd,
  input  logic [K-1:0] addr_a,
  input  logic [K-1:0] addr_b,
  input  logic         sel5,
  input  logic         sel6,
  input  logic         nb_mux5,
  input  logic [1:0]   add_a,
  input  logic [1:0]   add_b,
  input  logic         cin,
  output logic         y_a,
  output logic         y_b,
  output logic         q_a,
  output logic         q_b,
  output logic         mux5,
  output logic         mux6,
  output logic [1:0]   sum,
  output logic         cout
);
  localparam int DEPTH = 1 << K;

  logic [DEPTH-1:0] tab_a, tab_b;
  logic [K-1:0]     idx_b;
  logic [2:0]       c;

  assign idx_b = (mem_mode || share_in) ? addr_a : addr_b;
  assign y_a   = tab_a[addr_a];
  assign y_b   = tab_b[idx_b];
  assign mux5  = sel5 ? y_b : y_a;
  assign mux6  = sel6 ? nb_mux5 : mux5;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tab_a <= '0;
      tab_b <= '0;
      q_a   <= 1'b0;
      q_b   <= 1'b0;
    end else begin
      if (mem_mode && we) begin
        tab_a[addr_a] <= wd[0];
        tab_b[addr_a] <= wd[1];
      end
      q_a <= y_a;
      q_b <= y_b;
    end
  end

  assign c[0] = cin;
  for (genvar i = 0; i < 2; i++) begin : g_carry
    assign sum[i]  = add_a[i] ^ add_b[i] ^ c[i];
    assign c[i+1]  = (add_a[i] & add_b[i]) | (c[i] & (add_a[i] ^ add_b[i]));
  end
  assign cout = c[2];

  // R3: registered outputs lag the table outputs by one edge
  a_r3_reg_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_a == $past(y_a)) && (q_b == $past(y_b)));

  // R7: a memory write lands at the addressed word
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_mode && we) |=> (tab_a[$past(addr_a)] == $past(wd[0])) &&
                         (tab_b[$past(addr_a)] == $past(wd[1])));

  // R9: logic mode never alters the tables
  a_r9_logic_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_mode |=> $stable(tab_a) && $stable(tab_b));

  // R5: with both selects low the wide path carries table A
  a_r5_wide_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel5 && !sel6) |-> (mux6 == y_a));

  // R1: reset clears the registered outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> !q_a && !q_b);

  // R6: the chained carry matches a 2-bit addition
  always_comb begin
    if (rst_n)
      a_r6_carry_sum: assert ({cout, sum} == {1'b0, add_a} + {1'b0, add_b} + {2'b0, cin});
  end
endmodule

// File: tb/test_logic_slice2.sv
`timescale 1ns/1ps
module test_logic_slice2;
  logic clk = 0, rst_n = 0;
  logic mem_mode = 0, share_in = 0, we = 0, sel5 = 0, sel6 = 0, nb_mux5 = 0, cin = 0;
  logic [1:0] wd = 0, add_a = 0, add_b = 0;
  logic [3:0] addr_a = 0, addr_b = 0;
  logic y_a, y_b, q_a, q_b, mux5, mux6, cout;
  logic [1:0] sum;
  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  logic_slice2 i_logic_slice2 (
    .clk(clk), .rst_n(rst_n), .mem_mode(mem_mode), .share_in(share_in), .we(we), .wd(wd),
    .addr_a(addr_a), .addr_b(addr_b), .sel5(sel5), .sel6(sel6), .nb_mux5(nb_mux5),
    .add_a(add_a), .add_b(add_b), .cin(cin), .y_a(y_a), .y_b(y_b), .q_a(q_a), .q_b(q_b),
    .mux5(mux5), .mux6(mux6), .sum(sum), .cout(cout));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  task automatic write_word(input logic [3:0] a, input logic [1:0] d);
    @(negedge clk);
    mem_mode = 1; we = 1; addr_a = a; wd = d;
    @(posedge clk);
  endtask

  task automatic load(input logic [15:0] ta, input logic [15:0] tb);
    for (int i = 0; i < 16; i++) write_word(4'(i), {tb[i], ta[i]});
    @(negedge clk);
    we = 0; mem_mode = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(q_a == 0 && q_b == 0, "R1 q after reset", {q_a, q_b}, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      addr_a = 4'(i); addr_b = 4'(15 - i); sel5 = i[0]; sel6 = 0;
      #1;
      check({y_a, y_b, mux5, mux6} == 0, "R1 tables cleared", {y_a, y_b, mux5, mux6}, 0);
    end
  endtask

  task automatic t_indep();
    logic [15:0] ta = 16'hA5C3, tb = 16'h1E78;
    load(ta, tb);
    share_in = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      addr_a = 4'(i); addr_b = 4'((i * 7) & 15);
      #1;
      check(y_a == ta[i], "R2 table A", y_a, ta[i]);
      check(y_b == tb[(i * 7) & 15], "R2 table B", y_b, tb[(i * 7) & 15]);
    end
  endtask

  task automatic t_reg();
    logic [15:0] ta = 16'h00FF, tb = 16'h0F0F;
    load(ta, tb);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      addr_a = 4'(i); addr_b = 4'(i);
      @(posedge clk);
      #1;
      check(q_a == ta[i] && q_b == tb[i], "R3 registered", {q_a, q_b}, {tb[i], ta[i]});
    end
  endtask

  task automatic t_wide5(input logic [31:0] t);
    load(t[15:0], t[31:16]);
    share_in = 1; sel6 = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      sel5 = i[4]; addr_a = i[3:0]; addr_b = ~i[3:0];
      #1;
      check(mux5 == t[i], "R4 5-input", mux5, t[i]);
    end
    share_in = 0;
  endtask

  task automatic t_wide6();
    logic [31:0] t = 32'h6B1D_93E4;
    logic [31:0] n = 32'hC0FF_EE12;
    load(t[15:0], t[31:16]);
    share_in = 1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      sel6 = i[5]; sel5 = i[4]; addr_a = i[3:0]; nb_mux5 = n[i[4:0]];
      #1;
      check(mux6 == (i[5] ? n[i[4:0]] : t[i[4:0]]), "R5 6-input", mux6,
            i[5] ? n[i[4:0]] : t[i[4:0]]);
    end
    share_in = 0; sel6 = 0;
  endtask

  task automatic t_carry();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      add_a = i[1:0]; add_b = i[3:2]; cin = i[4];
      #1;
      check({cout, sum} == i[1:0] + i[3:2] + i[4], "R6 carry chain", {cout, sum},
            i[1:0] + i[3:2] + i[4]);
    end
  endtask

  task automatic t_mem();
    load(16'h0000, 16'hFFFF);
    @(negedge clk);
    mem_mode = 1; we = 1; addr_a = 4'd9; addr_b = 4'd2; wd = 2'b01;
    #1;
    check({y_b, y_a} == 2'b10, "R7 old word before edge", {y_b, y_a}, 2);
    @(posedge clk);
    #1;
    check({y_b, y_a} == 2'b01, "R7 new word after edge", {y_b, y_a}, 1);
    @(negedge clk);
    we = 0;
    for (int j = 0; j < 16; j++) begin
      addr_b = 4'(j);
      #0.1;
      check(y_b == 0, "R8 addr_b ignored in memory mode", y_b, 0);
    end
    mem_mode = 0; addr_b = 4'd2;
    #1;
    check(y_b == 1, "R8 addr_b used in logic mode", y_b, 1);
  endtask

  task automatic t_ignore();
    @(negedge clk);
    mem_mode = 0; we = 1; addr_a = 4'd9; wd = 2'b10;
    repeat (2) @(posedge clk);
    @(negedge clk);
    we = 0; mem_mode = 1; addr_a = 4'd9;
    #1;
    check({y_b, y_a} == 2'b01, "R9 logic-mode write ignored", {y_b, y_a}, 1);
    mem_mode = 0; addr_a = 4'd4; addr_b = 4'd4;
    #1;
    check({y_b, y_a} == 2'b10, "R9 contents persist", {y_b, y_a}, 2);
  endtask

  initial begin
    t_reset();
    t_indep();
    t_reg();
    t_wide5(32'hDEAD_BEEF);
    t_wide5(32'h8421_7BE0);
    t_wide6();
    t_carry();
    t_mem();
    t_ignore();
    finish_run();
  end
endmodule